// File: doc/BRIEF.md
# Phase-Modulated NCO Sine Datapath

This block is a numerically controlled oscillator that emits one unsigned sine sample on every master clock cycle. A wide phase accumulator advances by one of two tuning words, picked live by a frequency-select pin. One of four phase offsets, picked live by two phase-select pins, is added to the top bits of the accumulator. The sum addresses a quarter-wave sine function, which produces an offset-binary amplitude.

The tuning words and offsets come from a companion register bank as plain inputs. They can be changed on any cycle. Every select or word change reaches the output exactly six clock edges later.

Reset clears the accumulator and the pipeline, so the output sits at midscale. Sleep freezes all internal state until it is released, and processing then continues from where it stopped.

Top module: `nco_sine_core`

## Requirements
- R1: On every active clock edge the accumulator (ACC_W = 32 bits) adds the selected tuning word modulo 2^32. Output frequency is word × fclk / 2^32. A word of 0x4000_0000 gives the repeating sample cycle 512, 1023, 511, 0.
- R2: `fsel` is sampled on the rising edge. 0 selects `ftw0` and 1 selects `ftw1`. While `fsel` is 0, `ftw1` has no effect on the output.
- R3: `psel` is sampled on the rising edge. 2'b00 selects `ofs0`, 2'b01 selects `ofs1`, 2'b10 selects `ofs2` and 2'b11 selects `ofs3`.
- R4: The selected 12-bit offset is added to accumulator bits [31:20], and the sum wraps modulo 4096. Each offset step is 2π/4096.
- R5: A 12-bit phase p maps to an offset-binary sample. For p < 2048 the sample is 512 + round(511·sin(2π(p+0.5)/4096)). For p ≥ 2048 it is 511 − round(511·|sin(2π(p+0.5)/4096)|). The tolerance is ±1 LSB. Phase 0 gives 512, phase 1024 gives 1023, phase 2048 gives 511 and phase 3072 gives 0.
- R6: A change on `fsel`, `psel`, or the selected word or offset, sampled at edge k, first shows at `sample` after edge k+5.
- R7: While `rst_n` is low, the accumulator is zero and `sample` is 512. With zero tuning words after reset, `sample` stays 512.
- R8: While `sleep_n` is low, the accumulator, the pipeline and `sample` hold their values. After release, the output continues as if the sleep cycles had not occurred.
- R9: Switching `fsel` never reloads the accumulator, so the phase stays continuous across a switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, clears accumulator and pipeline |
| sleep_n | input | 1 | Active-low sleep, freezes all state |
| fsel | input | 1 | Tuning word select |
| psel | input | 2 | Phase offset select |
| ftw0 | input | 32 | Tuning word 0 |
| ftw1 | input | 32 | Tuning word 1 |
| ofs0 | input | 12 | Phase offset 0 |
| ofs1 | input | 12 | Phase offset 1 |
| ofs2 | input | 12 | Phase offset 2 |
| ofs3 | input | 12 | Phase offset 3 |
| sample | output | 10 | Offset-binary sine sample |

## Verification
The bench builds the block with its default widths: a 32-bit accumulator, a 12-bit phase and a 10-bit amplitude. This lets offsets and quarter-turn tuning words land exactly on the midscale, peak and trough codes. It also lets the offset sum be driven past 4095 to show the wrap.

A cycle-level reference model compares every output sample with a real-valued sine, so the six-edge alignment of select, word and offset paths is checked on every cycle. Sleep and reset are checked against that model: the output must hold during sleep and continue on release, and reset must force midscale.

// File: rtl/nco_sine_core.sv
module nco_sine_core #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_n,
  input  logic             fsel,
  input  logic [1:0]       psel,
  input  logic [ACC_W-1:0] ftw0,
  input  logic [ACC_W-1:0] ftw1,
  input  logic [PH_W-1:0]  ofs0,
  input  logic [PH_W-1:0]  ofs1,
  input  logic [PH_W-1:0]  ofs2,
  input  logic [PH_W-1:0]  ofs3,
  output logic [AMP_W-1:0] sample
);
  localparam int QW = PH_W - 2;
  localparam int MW = AMP_W - 1;
  localparam int SH = QW + 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << MW;
  localparam logic [47:0] MMAX = 48'((1 << MW) - 1);

  // Quarter-wave magnitude: odd series of sin(pi*t/2) in Q16, t = (2i+1)/2^SH
  function automatic logic [MW-1:0] sine_mag(input logic [QW-1:0] i);
    logic [47:0] u, t2, h, m;
    u  = (48'(i) << 1) | 48'd1;
    t2 = (u * u) >> SH;
    h  = 48'd307    - ((t2 * 48'd11)  >> SH);
    h  = 48'd5223   - ((t2 * h) >> SH);
    h  = 48'd42334  - ((t2 * h) >> SH);
    h  = 48'd102944 - ((t2 * h) >> SH);
    h  = (u * h) >> SH;
    m  = (h * MMAX + 48'd32768) >> 16;
    if (m > MMAX) m = MMAX;
    return m[MW-1:0];
  endfunction

  logic [ACC_W-1:0] inc_q, acc_q;
  logic [PH_W-1:0]  ofs_sel, ofs1_q, ofs2_q, ph_q;
  logic [QW-1:0]    idx_q;
  logic [MW-1:0]    mag_q;
  logic             neg4_q, neg5_q;

  always_comb begin
    case (psel)
      2'b00:   ofs_sel = ofs0;
      2'b01:   ofs_sel = ofs1;
      2'b10:   ofs_sel = ofs2;
      default: ofs_sel = ofs3;
    endcase
  end

  wire [PH_W-1:0] acc_top = acc_q[ACC_W-1 -: PH_W];
  wire [QW-1:0]   ph_idx  = ph_q[QW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q  <= '0;
      ofs1_q <= '0;
      acc_q  <= '0;
      ofs2_q <= '0;
      ph_q   <= '0;
      idx_q  <= '0;
      neg4_q <= 1'b0;
      mag_q  <= '0;
      neg5_q <= 1'b0;
      sample <= MID;
    end else if (sleep_n) begin
      inc_q  <= fsel ? ftw1 : ftw0;
      ofs1_q <= ofs_sel;
      acc_q  <= acc_q + inc_q;
      ofs2_q <= ofs1_q;
      ph_q   <= acc_top + ofs2_q;
      idx_q  <= ph_q[PH_W-2] ? ~ph_idx : ph_idx;
      neg4_q <= ph_q[PH_W-1];
      mag_q  <= sine_mag(idx_q);
      neg5_q <= neg4_q;
      sample <= neg5_q ? {1'b0, ~mag_q} : {1'b1, mag_q};
    end
  end
endmodule

// File: rtl/nco_sine_core_chk.sv
module nco_sine_core_chk #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_n,
  input logic             fsel,
  input logic [ACC_W-1:0] ftw0,
  input logic [ACC_W-1:0] ftw1,
  input logic [ACC_W-1:0] acc,
  input logic [AMP_W-1:0] sample
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

  assert_reset_mid_R7: assert property (@(posedge clk) !rst_n |=> sample == MID);
  assert_reset_acc_R7: assert property (@(posedge clk) !rst_n |=> acc == '0);
  assert_sleep_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> $stable(sample));
  assert_sleep_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> $stable(acc));
  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep_n) && $past(sleep_n, 2) && $past(rst_n) && $past(rst_n, 2))
    |-> (ACC_W'(acc - $past(acc)) == ($past(fsel, 2) ? $past(ftw1, 2) : $past(ftw0, 2))));
endmodule

bind nco_sine_core nco_sine_core_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .fsel(fsel),
  .ftw0(ftw0), .ftw1(ftw1), .acc(acc_q), .sample(sample)
);

// File: tb/nco_sine_core_tb.sv
`timescale 1ns/1ps
module nco_sine_core_tb;
  logic clk = 1'b0, rst_n = 1'b0, sleep_n = 1'b1, fsel = 1'b0;
  logic [1:0]  psel = 2'b00;
  logic [31:0] ftw0 = '0, ftw1 = '0;
  logic [11:0] ofs0 = '0, ofs1 = '0, ofs2 = '0, ofs3 = '0;
  logic [9:0]  sample;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nco_sine_core u_dut (.clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .fsel(fsel), .psel(psel),
    .ftw0(ftw0), .ftw1(ftw1), .ofs0(ofs0), .ofs1(ofs1), .ofs2(ofs2), .ofs3(ofs3), .sample(sample));

  function automatic int ref_sine(int p);
    real v;
    v = $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 4096.0);
    if (p < 2048) return 512 + $rtoi(511.0 * v + 0.5);
    return 511 - $rtoi(-511.0 * v + 0.5);
  endfunction

  // Reference model (R1, R4, R5, R6, R9)
  logic [31:0] m_acc, m_inc;
  logic [11:0] m_off, m_ph;
  int q[5];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = '0; m_inc = '0; m_off = '0;
      for (int i = 0; i < 5; i++) q[i] = 512;
    end else if (sleep_n) begin
      m_acc = m_acc + m_inc;
      m_ph  = m_acc[31:20] + m_off;
      m_inc = fsel ? ftw1 : ftw0;
      case (psel)
        2'b00: m_off = ofs0;
        2'b01: m_off = ofs1;
        2'b10: m_off = ofs2;
        default: m_off = ofs3;
      endcase
      for (int i = 4; i > 0; i--) q[i] = q[i-1];
      q[0] = ref_sine(int'(m_ph));
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) chk((int'(sample) - q[4] <= 1) && (q[4] - int'(sample) <= 1),
                   "R5/R6 model", int'(sample), q[4]);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    cyc(3);
    chk(sample == 10'd512, "R7 reset midscale", int'(sample), 512);
    rst_n = 1'b1;
  endtask

  task automatic t_zero_word();
    ftw0 = '0; ftw1 = 32'h4000_0000; fsel = 1'b0; psel = 2'b00; ofs0 = '0;
    do_reset();
    cyc(10);
    for (int i = 0; i < 4; i++) begin
      chk(sample == 10'd512, "R7/R2 zero word, ftw1 ignored", int'(sample), 512);
      cyc(1);
    end
  endtask

  task automatic t_quarter_turn();
    int s[4];
    ftw0 = 32'h4000_0000; fsel = 1'b0; psel = 2'b00; ofs0 = '0;
    do_reset();
    cyc(8);
    while (sample != 10'd512) cyc(1);
    for (int i = 0; i < 4; i++) begin s[i] = int'(sample); cyc(1); end
    chk(s[1] == 1023, "R1 quarter step peak", s[1], 1023);
    chk(s[2] == 511,  "R1 quarter step half", s[2], 511);
    chk(s[3] == 0,    "R1 quarter step trough", s[3], 0);
  endtask

  task automatic t_psel();
    int exp[4] = '{512, 1023, 511, 0};
    ftw0 = '0; fsel = 1'b0; ofs0 = 12'd0; ofs1 = 12'd1024; ofs2 = 12'd2048; ofs3 = 12'd3072;
    do_reset();
    for (int k = 0; k < 4; k++) begin
      psel = 2'(k);
      cyc(8);
      chk(int'(sample) == exp[k], "R3 phase select", int'(sample), exp[k]);
    end
  endtask

  task automatic t_latency();
    ftw0 = '0; psel = 2'b00; ofs0 = '0; ofs1 = 12'd1024;
    do_reset();
    cyc(8);
    psel = 2'b01;
    for (int e = 0; e < 5; e++) begin
      cyc(1);
      chk(sample == 10'd512, "R6 before six edges", int'(sample), 512);
    end
    cyc(1);
    chk(sample == 10'd1023, "R6 at sixth edge", int'(sample), 1023);
  endtask

  task automatic t_wrap();
    int a, b;
    ftw0 = 32'h8000_0000; psel = 2'b11; ofs3 = 12'd3072;
    do_reset();
    cyc(10);
    a = int'(sample); cyc(1); b = int'(sample);
    chk((a == 0 && b == 1023) || (a == 1023 && b == 0), "R4 offset wrap", a * 1024 + b, 1023);
  endtask

  task automatic t_sleep();
    logic [9:0] held;
    ftw0 = 32'h0123_4567; ftw1 = 32'h0765_4321; psel = 2'b10; ofs2 = 12'd333;
    do_reset();
    cyc(20);
    sleep_n = 1'b0;
    cyc(1);
    held = sample;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      chk(sample == held, "R8 sleep hold", int'(sample), int'(held));
    end
    sleep_n = 1'b1;
    cyc(30);
  endtask

  task automatic t_switch();
    ftw0 = 32'h0200_0000; ftw1 = 32'h0531_0000; psel = 2'b00; ofs0 = 12'd100;
    do_reset();
    for (int i = 0; i < 12; i++) begin
      fsel = ~fsel;
      cyc(7 + i);
    end
    for (int i = 0; i < 16; i++) begin
      psel = 2'(i);
      ofs1 = 12'(i * 517);
      cyc(3);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    cyc(2);
    t_zero_word();
    t_quarter_turn();
    t_psel();
    t_latency();
    t_wrap();
    t_sleep();
    t_switch();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule